// File: doc/BRIEF.md
# Saturating Signed Adder with Condition Flags

This block adds two 16-bit two's complement operands and a carry-in bit in a single combinational pass. When the saturation mode input is low, the result wraps modulo 2^16 like any ordinary binary adder. When it is high, a signed overflow clamps the result to the largest positive value (0x7FFF) or the most negative value (0x8000), whichever matches the direction of the overflow.

Four condition flags come out alongside the result. Negative and zero describe the value actually delivered on the result port, after any clamping. Carry and overflow always describe the raw, unclamped addition, so downstream logic can still see that a clamp happened. The block has no clock, no state and no reset. Every output is a pure function of the present inputs.

Top module: `sat_add_flags`

## Requirements
- R1: With `sat_mode` = 0, `result` equals (`opnd_a` + `opnd_b` + `carry_in`) modulo 2^16, with the operands taken as unsigned.
- R2: With `sat_mode` = 1 and no signed overflow, `result` equals the same sum as in R1.
- R3: With `sat_mode` = 1, when the sign bits (bit 15) of both operands are 0 and the signed sum is above 32767, `result` is 0x7FFF.
- R4: With `sat_mode` = 1, when the sign bits of both operands are 1 and the signed sum is below -32768, `result` is 0x8000.
- R5: `flag_v` is 1 exactly when the operands share the same bit 15 and bit 15 of the wrapped 16-bit sum differs from it. This holds whatever the value of `sat_mode`.
- R6: `flag_c` is bit 16 of the unsigned 17-bit sum `opnd_a` + `opnd_b` + `carry_in`, whatever the value of `sat_mode`.
- R7: `flag_n` equals bit 15 of `result` after any clamping.
- R8: `flag_z` is 1 exactly when all 16 bits of `result` are 0, judged after any clamping.
- R9: All outputs are combinational. After an input change they take their new values with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First signed operand |
| opnd_b | input | 16 | Second signed operand |
| carry_in | input | 1 | Carry added at bit 0 |
| sat_mode | input | 1 | 1 = clamp on signed overflow, 0 = wrap |
| result | output | 16 | Sum, wrapped or clamped |
| flag_c | output | 1 | Unsigned carry out of bit 15 |
| flag_n | output | 1 | Result is negative |
| flag_z | output | 1 | Result is zero |
| flag_v | output | 1 | Raw addition overflowed as signed |

## Verification
Every result and flag is due in the same cycle as its stimulus, because no register lies anywhere between the inputs and the outputs. The bench changes the operands just after a rising edge of its pacing clock. It compares all five outputs against its integer reference model at the next falling edge, before the next stimulus is applied. A clock edge therefore never separates the stimulus from the check, and any added latency would show up as a mismatch against the current vector.

// File: rtl/sat_add_flags.sv
module sat_add_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_in,
  input  logic         sat_mode,
  output logic [W-1:0] result,
  output logic         flag_c,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v
);

  localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   raw;
  logic         same_sign;
  logic [W-1:0] clamp_val;

  assign raw       = {1'b0, opnd_a} + {1'b0, opnd_b} + {{W{1'b0}}, carry_in};
  assign same_sign = (opnd_a[W-1] == opnd_b[W-1]);
  assign flag_v    = same_sign && (raw[W-1] != opnd_a[W-1]);
  assign flag_c    = raw[W];
  assign clamp_val = opnd_a[W-1] ? NEG_LIMIT : POS_LIMIT;
  assign result    = (sat_mode && flag_v) ? clamp_val : raw[W-1:0];
  assign flag_n    = result[W-1];
  assign flag_z    = (result == '0);

endmodule

module sat_add_flags_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         carry_in,
  input logic         sat_mode,
  input logic [W-1:0] result,
  input logic         flag_c,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_v
);

  logic [W:0] wide;
  assign wide = {1'b0, opnd_a} + {1'b0, opnd_b} + {{W{1'b0}}, carry_in};

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, carry_in, sat_mode})) begin
      assert_wrap_R1: assert (sat_mode || ({flag_c, result} == wide));
      assert_pass_R2: assert (!sat_mode || flag_v || (result == wide[W-1:0]));
      assert_clamp_pos_R3: assert (!(sat_mode && flag_v && !opnd_a[W-1]) || (result == {1'b0, {(W-1){1'b1}}}));
      assert_clamp_neg_R4: assert (!(sat_mode && flag_v && opnd_a[W-1]) || (result == {1'b1, {(W-1){1'b0}}}));
      assert_ovf_sign_R5: assert (!flag_v || (opnd_a[W-1] == opnd_b[W-1]));
      assert_clamp_sign_R7: assert (!(sat_mode && flag_v) || (flag_n == opnd_a[W-1]));
      assert_zero_pos_R8: assert (!flag_z || !flag_n);
    end
  end

endmodule

bind sat_add_flags sat_add_flags_chk #(.W(W)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .sat_mode(sat_mode),
  .result(result), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
);

// File: tb/sim_sat_add_flags.sv
module sim_sat_add_flags;

  logic        clk = 1'b0;
  logic [15:0] a, b;
  logic        ci, sat;
  logic [15:0] res;
  logic        fc, fn, fz, fv;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sat_add_flags u0 (
    .opnd_a(a), .opnd_b(b), .carry_in(ci), .sat_mode(sat),
    .result(res), .flag_c(fc), .flag_n(fn), .flag_z(fz), .flag_v(fv)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h ci=%0d sat=%0d actual=%h expected=%h", tag, a, b, ci, sat, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] va, input logic [15:0] vb, input logic vc, input logic vs);
    int ua, sa, ex_r, ex_c, ex_v;
    string tag;
    @(posedge clk);
    a = va; b = vb; ci = vc; sat = vs;
    ua = int'(va) + int'(vb) + int'(vc);
    sa = int'($signed(va)) + int'($signed(vb)) + int'(vc);
    ex_c = (ua >= 65536) ? 1 : 0;
    ex_v = (sa > 32767 || sa < -32768) ? 1 : 0;
    ex_r = ua % 65536;
    tag = "R1";
    if (vs) begin
      if (sa > 32767) begin ex_r = 16'h7fff; tag = "R3"; end
      else if (sa < -32768) begin ex_r = 16'h8000; tag = "R4"; end
      else tag = "R2";
    end
    @(negedge clk);
    chk({tag, "/R9 result"}, int'(res), ex_r);
    chk("R5 flag_v", int'(fv), ex_v);
    chk("R6 flag_c", int'(fc), ex_c);
    chk("R7 flag_n", int'(fn), (ex_r >= 32768) ? 1 : 0);
    chk("R8 flag_z", int'(fz), (ex_r == 0) ? 1 : 0);
  endtask

  initial begin
    a = 16'h0; b = 16'h0; ci = 1'b0; sat = 1'b0;
    @(negedge clk);
    chk("R8 idle zero", int'(fz), 1);
    chk("R1 idle result", int'(res), 0);
    run(16'h7fff, 16'h0001, 1'b0, 1'b0);
    run(16'h7fff, 16'h0001, 1'b0, 1'b1);
    run(16'h8000, 16'hffff, 1'b0, 1'b0);
    run(16'h8000, 16'hffff, 1'b0, 1'b1);
    run(16'h7fff, 16'h0000, 1'b1, 1'b0);
    run(16'h7fff, 16'h0000, 1'b1, 1'b1);
    run(16'h8000, 16'h8000, 1'b0, 1'b0);
    run(16'h8000, 16'h8000, 1'b0, 1'b1);
    run(16'hffff, 16'h0001, 1'b0, 1'b1);
    run(16'hffff, 16'h0000, 1'b1, 1'b0);
    run(16'h7fff, 16'h7fff, 1'b1, 1'b1);
    run(16'h8000, 16'h7fff, 1'b1, 1'b1);
    run(16'h1234, 16'h4321, 1'b0, 1'b1);
    run(16'hc000, 16'hbfff, 1'b1, 1'b1);
    for (int i = 0; i < 2000; i++)
      run(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule